// File: doc/BRIEF.md
# Reset Mode and Vector Fetch Sequencer

This block brings a 16-bit microcontroller core with a 24-bit address space out of reset. Once the synchronous reset is released it reads one configuration byte, then three bytes that give the start address. The configuration byte sets the bus mode and the bus width. The three address bytes load a 16-bit program counter and an 8-bit bank register. After that the block raises a one-cycle start pulse and holds a running flag, and the core begins executing.

Every read goes out on a byte-wide request/acknowledge port. An extra select line picks either internal ROM/flash or the external bus. The mode pins choose the source: they are sampled once, on release, and that choice applies to all four reads.

The configuration byte is staged while the sequence runs. It reaches the bus-mode and bus-width outputs only when the last address byte has been taken. Once reset is over it cannot be written: a store aimed at its address has no effect.

Top module: `boot_fetch_seq`

## Requirements
- R1: After reset release, the first read is at 0xFFFFDF (configuration byte), followed by reads at 0xFFFFDC, 0xFFFFDD and 0xFFFFDE in that order.
- R2: `rd_ext` is 0 (internal ROM) when the sampled mode pins equal 3'b011 and 1 (external bus) for any other value, identically for all four reads.
- R3: The mode pins are sampled in the first clock cycle with `rst_n` high. Later changes on them do not alter the source of any read in that sequence.
- R4: While `rd_req` is high and `rd_ack` is low, `rd_req`, `rd_addr` and `rd_ext` stay unchanged on the next cycle. `rd_data` is taken on the cycle in which `rd_ack` is high.
- R5: After the sequence, `pc` equals {byte at 0xFFFFDD, byte at 0xFFFFDC} and `pcb` equals the byte at 0xFFFFDE.
- R6: `bus_mode` is bits 7:6 and `wide_bus` is bit 2 of the configuration byte. Both stay at 0 until the last address byte is acknowledged, and they change in the same cycle that `pc` loads.
- R7: `start_pulse` is high for exactly one cycle, the cycle after the final acknowledge. `running` rises in that same cycle and stays high until reset.
- R8: A store on the write port to 0xFFFFDF, before or after start-up, never changes `bus_mode` or `wide_bus`.
- R9: Driving `rst_n` low at any point aborts the sequence. On the next cycle `rd_req`, `running`, `start_pulse`, `pc`, `pcb`, `bus_mode` and `wide_bus` are all 0, and a full fresh sequence follows the next release.
- R10: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pins | input | 3 | Boot source select pins |
| rd_ack | input | 1 | Read acknowledge; data valid |
| rd_data | input | 8 | Read data byte |
| rd_req | output | 1 | Read request |
| rd_addr | output | 24 | Read byte address |
| rd_ext | output | 1 | 1 = external bus, 0 = internal ROM |
| sw_wr_en | input | 1 | Software store strobe |
| sw_wr_addr | input | 24 | Software store address |
| sw_wr_data | input | 8 | Software store data |
| pc | output | 16 | Program counter start value |
| pcb | output | 8 | Program bank start value |
| bus_mode | output | 2 | Effective bus mode |
| wide_bus | output | 1 | Effective bus width select |
| start_pulse | output | 1 | One-cycle start strobe |
| running | output | 1 | Core may execute |

## Verification
The hardest case to reach from the ports is a read held in a wait state while the mode pins move, or while reset cuts in halfway. Only then does pin latching, address holding and abort behaviour differ from a design that reads the pins live. The memory model in the bench inserts zero to three random wait cycles per read and flips the pins right after release in random runs. A directed run also pulls reset low while a vector byte is pending and then checks that a clean second sequence follows.

// File: rtl/boot_pkg.sv
// Shared constants and state type for the start-up fetch sequencer.
// Assumes a byte-addressed 24-bit space with the boot block at its top.
package boot_pkg;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 8;
    localparam int PIN_W  = 3;
    localparam int VEC_BYTES = 3;
    localparam logic [ADDR_W-1:0] CFG_ADDR = 24'hFFFFDF;
    localparam logic [ADDR_W-1:0] VEC_BASE = 24'hFFFFDC;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CFG, ST_V0, ST_V1, ST_V2, ST_RUN
    } boot_st_e;
endpackage

// File: rtl/boot_fsm.sv
// Fetch sequencer: latches the source pins on release, issues four
// handshaked byte reads (config byte then vector low-to-high), and
// flags the end of the sequence. Assumes rd_ack only while rd_req.
module boot_fsm
    import boot_pkg::*;
#(
    parameter logic [PIN_W-1:0] INT_CODE = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  mode_pins,
    input  logic              rd_ack,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ext,
    output logic              cfg_take,
    output logic [VEC_BYTES-1:0] vec_take,
    output logic              vec_done,
    output logic              start_pulse,
    output logic              running
);
    boot_st_e state;
    logic     ext_q;

    // State advance: one step per acknowledged read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ext_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    ext_q <= (mode_pins != INT_CODE);
                    state <= ST_CFG;
                end
                ST_CFG:  if (rd_ack) state <= ST_V0;
                ST_V0:   if (rd_ack) state <= ST_V1;
                ST_V1:   if (rd_ack) state <= ST_V2;
                ST_V2:   if (rd_ack) state <= ST_RUN;
                default: state <= ST_RUN;
            endcase
        end
    end

    // Start strobe and sticky run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            running     <= 1'b0;
        end else begin
            start_pulse <= vec_done;
            if (vec_done) running <= 1'b1;
        end
    end

    // Address and strobe decode from the current state.
    always_comb begin
        rd_req   = 1'b0;
        rd_addr  = '0;
        cfg_take = 1'b0;
        vec_take = '0;
        case (state)
            ST_CFG: begin
                rd_req = 1'b1; rd_addr = CFG_ADDR; cfg_take = rd_ack;
            end
            ST_V0: begin
                rd_req = 1'b1; rd_addr = VEC_BASE; vec_take[0] = rd_ack;
            end
            ST_V1: begin
                rd_req = 1'b1; rd_addr = VEC_BASE + 24'd1; vec_take[1] = rd_ack;
            end
            ST_V2: begin
                rd_req = 1'b1; rd_addr = VEC_BASE + 24'd2; vec_take[2] = rd_ack;
            end
            default: ;
        endcase
        rd_ext   = rd_req & ext_q;
        vec_done = vec_take[VEC_BYTES-1];
    end

    assert_hold_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr) && $stable(rd_ext));
    assert_cfg_then_vec_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_take |=> rd_req && rd_addr == VEC_BASE);
    assert_src_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && $past(rd_req) |-> $stable(rd_ext));
    assert_start_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse && running);
    assert_run_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running && !rd_req);
endmodule

// File: rtl/boot_vec_regs.sv
// Collects the three vector bytes and loads the program counter and
// bank register together when the last byte arrives.
module boot_vec_regs
    import boot_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    rd_data,
    input  logic [VEC_BYTES-1:0] vec_take,
    output logic [2*DATA_W-1:0]  pc,
    output logic [DATA_W-1:0]    pcb
);
    localparam int LOW_BYTES = VEC_BYTES - 1;
    logic [DATA_W-1:0] low_q [LOW_BYTES];

    for (genvar i = 0; i < LOW_BYTES; i++) begin : g_low
        // Holding register for one lower vector byte.
        always_ff @(posedge clk) begin
            if (!rst_n)           low_q[i] <= '0;
            else if (vec_take[i]) low_q[i] <= rd_data;
        end
    end

    // Final load: bank from the top byte, counter from the held bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= '0;
            pcb <= '0;
        end else if (vec_take[VEC_BYTES-1]) begin
            pcb <= rd_data;
            pc  <= {low_q[1], low_q[0]};
        end
    end

    assert_pc_only_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_take[VEC_BYTES-1] |=> $stable(pc) && $stable(pcb));
endmodule

// File: rtl/boot_mode_reg.sv
// Configuration byte: staged on its read, made effective when the
// vector is complete. No store path exists; the store port is only
// watched so the lock can be checked.
module boot_mode_reg
    import boot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              cfg_take,
    input  logic              vec_done,
    input  logic              sw_wr_en,
    input  logic [ADDR_W-1:0] sw_wr_addr,
    input  logic [DATA_W-1:0] sw_wr_data,
    output logic [1:0]        bus_mode,
    output logic              wide_bus
);
    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] eff_q;
    logic              sw_hit;

    // Staging register, loaded by the configuration read only.
    always_ff @(posedge clk) begin
        if (!rst_n)        stage_q <= '0;
        else if (cfg_take) stage_q <= rd_data;
    end

    // Effective register, loaded once the vector fetch completes.
    always_ff @(posedge clk) begin
        if (!rst_n)        eff_q <= '0;
        else if (vec_done) eff_q <= stage_q;
    end

    assign bus_mode = eff_q[7:6];
    assign wide_bus = eff_q[2];
    assign sw_hit   = sw_wr_en && (sw_wr_addr == CFG_ADDR) && (sw_wr_data != eff_q);

    assert_sw_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_hit && !vec_done |=> $stable(eff_q));
    assert_eff_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_done |=> $stable(bus_mode) && $stable(wide_bus));
endmodule

// File: rtl/boot_fetch_seq.sv
// Top: reset-release fetch of configuration byte and start vector.
// Assumes a synchronous active-low reset and one outstanding read.
module boot_fetch_seq
    import boot_pkg::*;
#(
    parameter logic [PIN_W-1:0] INT_CODE = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  mode_pins,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ext,
    input  logic              sw_wr_en,
    input  logic [ADDR_W-1:0] sw_wr_addr,
    input  logic [DATA_W-1:0] sw_wr_data,
    output logic [15:0]       pc,
    output logic [7:0]        pcb,
    output logic [1:0]        bus_mode,
    output logic              wide_bus,
    output logic              start_pulse,
    output logic              running
);
    logic                 cfg_take;
    logic [VEC_BYTES-1:0] vec_take;
    logic                 vec_done;

    boot_fsm #(.INT_CODE(INT_CODE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .rd_ack(rd_ack),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ext(rd_ext),
        .cfg_take(cfg_take), .vec_take(vec_take), .vec_done(vec_done),
        .start_pulse(start_pulse), .running(running)
    );

    boot_vec_regs u_vec (
        .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .vec_take(vec_take),
        .pc(pc), .pcb(pcb)
    );

    boot_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .cfg_take(cfg_take),
        .vec_done(vec_done), .sw_wr_en(sw_wr_en), .sw_wr_addr(sw_wr_addr),
        .sw_wr_data(sw_wr_data), .bus_mode(bus_mode), .wide_bus(wide_bus)
    );

    assert_start_with_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> running);
    assert_idle_after_reset_R9: assert property (@(posedge clk)
        !rst_n |=> !rd_req && !running && !start_pulse && pc == 16'h0);
endmodule

// File: tb/tb_boot_fetch_seq.sv
module tb_boot_fetch_seq;
    logic clk = 0, rst_n = 0;
    logic [2:0] mode_pins = 3'b011;
    logic rd_ack = 0;
    logic [7:0] rd_data = 0;
    logic rd_req, rd_ext, sw_wr_en = 0;
    logic [23:0] rd_addr, sw_wr_addr = 0;
    logic [7:0] sw_wr_data = 0;
    logic [15:0] pc;
    logic [7:0] pcb;
    logic [1:0] bus_mode;
    logic wide_bus, start_pulse, running;

    int total = 0, bad = 0;
    logic [7:0] int_mem [4];
    logic [7:0] ext_mem [4];
    logic [23:0] log_addr [8];
    logic        log_ext [8];
    int log_n = 0, wait_cnt = 0, start_cnt = 0;
    int hold_err = 0, early_err = 0;
    logic prev_wait = 0;
    logic [23:0] prev_addr = 0;
    logic prev_ext = 0;
    bit wd_fired = 0;

    boot_fetch_seq dut (.*);

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_rd(input logic [23:0] a, input logic e);
        return e ? ext_mem[a[1:0]] : int_mem[a[1:0]];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model with random wait states plus stability monitors.
    always @(negedge clk) begin
        if (rst_n && prev_wait && !(rd_req && rd_addr == prev_addr && rd_ext == prev_ext))
            hold_err++;
        if (rst_n && !running && (bus_mode != 0 || wide_bus)) early_err++;
        if (rst_n && start_pulse) start_cnt++;
        prev_wait = 0;
        if (!rd_req) begin
            rd_ack = 0; wait_cnt = $urandom % 4;
        end else if (rd_ack) begin
            rd_ack = 0; wait_cnt = $urandom % 4;
            prev_wait = rst_n; prev_addr = rd_addr; prev_ext = rd_ext;
        end else if (wait_cnt == 0) begin
            rd_ack = 1; rd_data = mem_rd(rd_addr, rd_ext);
            if (log_n < 8) begin
                log_addr[log_n] = rd_addr; log_ext[log_n] = rd_ext;
            end
            log_n++;
        end else begin
            wait_cnt--;
            prev_wait = rst_n; prev_addr = rd_addr; prev_ext = rd_ext;
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        log_n = 0; start_cnt = 0; hold_err = 0; early_err = 0;
    endtask

    task automatic wait_run();
        for (int i = 0; i < 200 && !running; i++) @(negedge clk);
    endtask

    task automatic full_run(input logic [2:0] pins, input bit flip);
        logic e;
        for (int i = 0; i < 4; i++) begin
            int_mem[i] = 8'($urandom); ext_mem[i] = 8'($urandom);
        end
        do_reset();
        mode_pins = pins;
        rst_n = 1;
        @(negedge clk);
        if (flip) mode_pins = ~pins;
        wait_run();
        repeat (3) @(negedge clk);
        e = (pins != 3'b011);
        chk("R1 read count", log_n, 4);
        chk("R1 first addr cfg", log_addr[0], 24'hFFFFDF);
        chk("R1 vec order", {log_addr[1][1:0], log_addr[2][1:0], log_addr[3][1:0]}, 6'b00_01_10);
        chk("R2 R3 source", {log_ext[0], log_ext[1], log_ext[2], log_ext[3]}, {4{e}});
        chk("R4 hold during wait", hold_err, 0);
        chk("R5 pc", pc, {mem_rd(24'hFFFFDD, e), mem_rd(24'hFFFFDC, e)});
        chk("R5 pcb", pcb, mem_rd(24'hFFFFDE, e));
        chk("R6 bus_mode", bus_mode, mem_rd(24'hFFFFDF, e) >> 6);
        chk("R6 wide_bus", wide_bus, (mem_rd(24'hFFFFDF, e) >> 2) & 1);
        chk("R6 not early", early_err, 0);
        chk("R7 one start pulse", start_cnt, 1);
        chk("R7 running", running, 1);
    endtask

    initial begin
        void'($urandom(32'd7011));
        repeat (2) @(negedge clk);
        chk("R10 reset outputs", {rd_req, running, start_pulse, pc, pcb, bus_mode, wide_bus}, 0);
        full_run(3'b011, 0);
        full_run(3'b000, 0);
        full_run(3'b011, 1);
        full_run(3'b101, 1);
        for (int r = 0; r < 8; r++) full_run(3'($urandom), r[0]);
        // R8: store to the config address after start-up
        begin
            logic [1:0] bm; logic wb;
            bm = bus_mode; wb = wide_bus;
            @(negedge clk);
            sw_wr_en = 1; sw_wr_addr = 24'hFFFFDF; sw_wr_data = ~{bm, 3'b0, wb, 2'b0};
            @(negedge clk); sw_wr_en = 0;
            repeat (2) @(negedge clk);
            chk("R8 locked after store", {bus_mode, wide_bus}, {bm, wb});
        end
        // R9: abort during a vector read, then a clean second pass
        int_mem[0] = 8'h34; int_mem[1] = 8'h12; int_mem[2] = 8'h56; int_mem[3] = 8'hC4;
        do_reset();
        mode_pins = 3'b011; rst_n = 1;
        for (int i = 0; i < 200 && log_n < 2; i++) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk("R9 abort clears", {rd_req, running, start_pulse, pc, pcb, bus_mode, wide_bus}, 0);
        log_n = 0; start_cnt = 0;
        rst_n = 1;
        wait_run();
        repeat (2) @(negedge clk);
        chk("R9 restart reads", log_n, 4);
        chk("R9 restart pc", {pcb, pc}, 24'h561234);
        chk("R9 restart mode", {bus_mode, wide_bus}, 3'b111);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        wd_fired = 1;
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule